// File: doc/BRIEF.md
# Store Buffer with Byte-Merge Load Forwarding

This block sits between a core's load/store unit and a word-wide data cache port. Stores of a byte, a halfword or a word, each marked with byte-lane enables, go into a small ordered queue. They reach the cache later, oldest first, whenever the cache port grants. A word load reads the cache and then lays the bytes of any queued stores to the same word over the cached value. The word it returns can therefore mix fresh lanes with older cached lanes, and no agent may ever have seen that word in memory.

Locked compare-and-swap operations follow a stricter path. The queue is emptied first. The cache line is then locked across the read and the conditional write. The unit accepts nothing new until that write has completed. An external agent may write the cache through a gate that the block controls. The gate refuses writes to the locked line while the lock is held.

Top module: `stbuf_fwd`

## Requirements
- R1: An accepted store (op code 2'b00) does not write the cache when it is accepted. Cache writes with `mem_we`=1 and no line lock come only from queued stores, and each carries that store's word address, data and byte enables.
- R2: Queued stores leave the queue in acceptance order, one per cycle in which `mem_req`, `mem_we` and `mem_gnt` are all high.
- R3: The queue holds DEPTH entries (default 4). While it is full, `req_ready` is low for a store request.
- R4: A load (op code 2'b01) issues a cache read. Its response gives the cached word with every lane covered by a queued store to the same word address replaced. For example, a cached 0x01010101 with a queued byte 0x03 in lane 0 returns 0x01010103. `rsp_valid` rises in the cycle after the granted read.
- R5: When several queued stores cover the same lane of the loaded word, that lane takes the byte of the youngest one. Each lane is resolved on its own.
- R6: A compare-and-swap (op code 2'b10) issues its read only after the queue is empty.
- R7: `line_locked` is high from the first cycle of the locked read through the cycle of the locked write, or through the decision cycle when no write is made. During that time `ext_wr_allow` is low for any external write whose address shares the locked word's line. A line is the word address with its low LINE_LG2 bits (default 2) dropped. At all other times `ext_wr_allow` is high.
- R8: The compare-and-swap writes its new value (`req_wdata`, all lanes) only when the word it read equals `req_cmp`. Its response returns the word read on `rsp_data`, and `rsp_ok` is high when the swap happened.
- R9: `rsp_valid` is a single-cycle pulse. No request is accepted from the start of a compare-and-swap until its response.
- R10: After reset the queue is empty, `req_ready` is high, `mem_req`, `line_locked` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 store, 01 load, 10 compare-and-swap |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data (lane aligned) or swap value |
| req_be | input | DW/8 | Byte-lane enables of a store |
| req_cmp | input | DW | Expected word of a compare-and-swap |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Load or swap result pulse |
| rsp_data | output | DW | Merged load word or word read by the swap |
| rsp_ok | output | 1 | Swap performed |
| mem_req | output | 1 | Cache access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Cache word address |
| mem_wdata | output | DW | Cache write data |
| mem_be | output | DW/8 | Cache write lane enables |
| mem_gnt | input | 1 | Cache accepts the access this cycle |
| mem_rdata | input | DW | Cache read word, valid in the granted cycle |
| line_locked | output | 1 | A cache line is locked by a swap |
| ext_wr_req | input | 1 | External agent wants to write |
| ext_wr_addr | input | AW | External write word address |
| ext_wr_allow | output | 1 | External write may proceed this cycle |

## Verification
The hardest case to reach is the load that returns a word no memory ever held. It needs a queued narrow store that cannot drain, a cache word that some other agent changes underneath it, and a load that is granted in between. The stimulus gets there by granting only reads, so that stores pile up. An external write sets the word, a byte store is queued and a load is issued. Then the external agent rewrites the upper lanes before writes are granted again. Random traffic then mixes narrow stores, loads and swaps over eight words spanning two lines, with grants at random and external writes attempted on most cycles. This keeps the lock gate under constant pressure.

// File: rtl/stb_pkg.sv
package stb_pkg;
   typedef enum logic [1:0] {
      OP_STORE = 2'b00,
      OP_LOAD  = 2'b01,
      OP_CAS   = 2'b10
   } stb_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_EMPTY,
      ST_LKRD,
      ST_LKWR
   } stb_state_e;
endpackage

// File: rtl/stb_fifo.sv
module stb_fifo #(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   input  logic [AW-1:0]         push_addr,
   input  logic [DW-1:0]         push_data,
   input  logic [DW/8-1:0]       push_be,
   input  logic                  pop,
   output logic [AW-1:0]         q_addr [DEPTH],
   output logic [DW-1:0]         q_data [DEPTH],
   output logic [DW/8-1:0]       q_be   [DEPTH],
   output logic [$clog2(DEPTH)-1:0] rd_ptr,
   output logic [$clog2(DEPTH):0]   count,
   output logic                  full,
   output logic                  empty,
   output logic [AW-1:0]         head_addr,
   output logic [DW-1:0]         head_data,
   output logic [DW/8-1:0]       head_be
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   logic [PW-1:0] wr_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         q_addr[wr_ptr] <= push_addr;
         q_data[wr_ptr] <= push_data;
         q_be[wr_ptr]   <= push_be;
      end
   end

   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);
   assign head_addr = q_addr[rd_ptr];
   assign head_data = q_data[rd_ptr];
   assign head_be   = q_be[rd_ptr];
endmodule

// File: rtl/stb_fwd.sv
module stb_fwd #(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic [AW-1:0]            q_addr [DEPTH],
   input  logic [DW-1:0]            q_data [DEPTH],
   input  logic [DW/8-1:0]          q_be   [DEPTH],
   input  logic [$clog2(DEPTH)-1:0] rd_ptr,
   input  logic [$clog2(DEPTH):0]   count,
   input  logic [AW-1:0]            ld_addr,
   input  logic [DW-1:0]            base,
   output logic [DW-1:0]            merged
);
   localparam int LANES = DW / 8;
   localparam int PW    = $clog2(DEPTH);
   localparam int CW    = PW + 1;

   // each lane walks the queue oldest to youngest; the last hit wins
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0]    lane_q;
      logic [PW-1:0] idx;
      always_comb begin
         lane_q = base[l*8 +: 8];
         idx    = '0;
         for (int i = 0; i < DEPTH; i++) begin
            idx = rd_ptr + PW'(i);
            if ((CW'(i) < count) && (q_addr[idx] == ld_addr) && q_be[idx][l])
               lane_q = q_data[idx][l*8 +: 8];
         end
      end
      assign merged[l*8 +: 8] = lane_q;
   end
endmodule

// File: rtl/stb_lockgate.sv
module stb_lockgate #(
   parameter int AW       = 8,
   parameter int LINE_LG2 = 2
) (
   input  logic          locked,
   input  logic [AW-1:0] lock_addr,
   input  logic [AW-1:0] ext_addr,
   output logic          allow
);
   logic same_line;

   if (LINE_LG2 == 0) begin : g_word
      assign same_line = (lock_addr == ext_addr);
   end else begin : g_line
      assign same_line = (lock_addr[AW-1:LINE_LG2] == ext_addr[AW-1:LINE_LG2]);
   end

   assign allow = !(locked && same_line);
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
   import stb_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 32,
   parameter int DEPTH    = 4,
   parameter int LINE_LG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [DW/8-1:0]  req_be,
   input  logic [DW-1:0]    req_cmp,
   output logic             req_ready,
   output logic             rsp_valid,
   output logic [DW-1:0]    rsp_data,
   output logic             rsp_ok,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   output logic [DW/8-1:0]  mem_be,
   input  logic             mem_gnt,
   input  logic [DW-1:0]    mem_rdata,
   output logic             line_locked,
   input  logic             ext_wr_req,
   input  logic [AW-1:0]    ext_wr_addr,
   output logic             ext_wr_allow
);
   localparam int LANES = DW / 8;
   localparam int PW    = $clog2(DEPTH);

   initial begin : p_param_chk
      assert (DW % 8 == 0 && DW >= 8) else $fatal(1, "DW must be a whole number of bytes");
      assert (DEPTH >= 2 && (1 << PW) == DEPTH) else $fatal(1, "DEPTH must be a power of two");
      assert (LINE_LG2 >= 0 && LINE_LG2 < AW) else $fatal(1, "LINE_LG2 out of range");
   end

   stb_state_e state;
   stb_op_e    op_in;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_new, op_cmp, old_r;
   logic          ok_r;

   logic [AW-1:0]    q_addr [DEPTH];
   logic [DW-1:0]    q_data [DEPTH];
   logic [LANES-1:0] q_be   [DEPTH];
   logic [PW-1:0]    rd_ptr;
   logic [PW:0]      count;
   logic             full, empty, push, pop, accept, drain_phase;
   logic [AW-1:0]    head_addr;
   logic [DW-1:0]    head_data, fwd_word;
   logic [LANES-1:0] head_be;

   assign op_in       = stb_op_e'(req_op);
   assign req_ready   = (state == ST_IDLE) && !(op_in == OP_STORE && full);
   assign accept      = req_valid && req_ready;
   assign push        = accept && (op_in == OP_STORE);
   assign drain_phase = (state == ST_IDLE) || (state == ST_EMPTY);
   assign pop         = drain_phase && !empty && mem_gnt;
   assign line_locked = (state == ST_LKRD) || (state == ST_LKWR);

   stb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_addr(req_addr),
      .push_data(req_wdata), .push_be(req_be), .pop(pop),
      .q_addr(q_addr), .q_data(q_data), .q_be(q_be), .rd_ptr(rd_ptr),
      .count(count), .full(full), .empty(empty),
      .head_addr(head_addr), .head_data(head_data), .head_be(head_be)
   );

   stb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
      .q_addr(q_addr), .q_data(q_data), .q_be(q_be), .rd_ptr(rd_ptr),
      .count(count), .ld_addr(op_addr), .base(mem_rdata), .merged(fwd_word)
   );

   stb_lockgate #(.AW(AW), .LINE_LG2(LINE_LG2)) u_gate (
      .locked(line_locked), .lock_addr(op_addr), .ext_addr(ext_wr_addr),
      .allow(ext_wr_allow)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = head_addr;
      mem_wdata = head_data;
      mem_be    = head_be;
      unique case (state)
         ST_IDLE, ST_EMPTY: begin
            mem_req = !empty;
            mem_we  = 1'b1;
         end
         ST_LOAD, ST_LKRD: begin
            mem_req  = 1'b1;
            mem_addr = op_addr;
            mem_be   = '1;
         end
         ST_LKWR: begin
            mem_req   = ok_r;
            mem_we    = 1'b1;
            mem_addr  = op_addr;
            mem_wdata = op_new;
            mem_be    = '1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_addr   <= '0;
         op_new    <= '0;
         op_cmp    <= '0;
         old_r     <= '0;
         ok_r      <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_ok    <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               op_addr <= req_addr;
               op_new  <= req_wdata;
               op_cmp  <= req_cmp;
               if (op_in == OP_LOAD)     state <= ST_LOAD;
               else if (op_in == OP_CAS) state <= ST_EMPTY;
            end
            ST_LOAD: if (mem_gnt) begin
               rsp_valid <= 1'b1;
               rsp_data  <= fwd_word;
               rsp_ok    <= 1'b0;
               state     <= ST_IDLE;
            end
            ST_EMPTY: if (empty) state <= ST_LKRD;
            ST_LKRD: if (mem_gnt) begin
               old_r <= mem_rdata;
               ok_r  <= (mem_rdata == op_cmp);
               state <= ST_LKWR;
            end
            ST_LKWR: if (!ok_r || mem_gnt) begin
               rsp_valid <= 1'b1;
               rsp_data  <= old_r;
               rsp_ok    <= ok_r;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/stb_chk.sv
module stb_chk #(
   parameter int AW       = 8,
   parameter int DEPTH    = 4,
   parameter int LINE_LG2 = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic [1:0]              req_op,
   input logic                    req_ready,
   input logic                    full,
   input logic                    empty,
   input logic [$clog2(DEPTH):0]  count,
   input logic                    mem_req,
   input logic                    mem_we,
   input logic [AW-1:0]           mem_addr,
   input logic                    line_locked,
   input logic                    ext_wr_req,
   input logic [AW-1:0]           ext_wr_addr,
   input logic                    ext_wr_allow,
   input logic                    rsp_valid
);
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && req_valid && req_op == 2'b00) |-> !req_ready); // R3
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= ($clog2(DEPTH)+1)'(DEPTH)); // R3
   AST_LOCK_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && line_locked) |-> empty); // R6
   AST_LOCK_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (line_locked && ext_wr_req &&
       (ext_wr_addr >> LINE_LG2) == (mem_addr >> LINE_LG2)) |-> !ext_wr_allow); // R7
   AST_UNLOCKED_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !line_locked |-> ext_wr_allow); // R7
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R9
   AST_LOCK_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      line_locked |-> !req_ready); // R9
endmodule

bind stbuf_fwd stb_chk #(.AW(AW), .DEPTH(DEPTH), .LINE_LG2(LINE_LG2)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_ready(req_ready), .full(full), .empty(empty), .count(count),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .line_locked(line_locked), .ext_wr_req(ext_wr_req),
   .ext_wr_addr(ext_wr_addr), .ext_wr_allow(ext_wr_allow),
   .rsp_valid(rsp_valid)
);

// File: tb/stbuf_fwd_tb.sv
`timescale 1ns/100ps
module stbuf_fwd_tb;
   localparam int AW = 8, DW = 32, DEPTH = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0, req_cmp = '0;
   logic [3:0] req_be = '0;
   logic req_ready, rsp_valid, rsp_ok, mem_req, mem_we, mem_gnt, line_locked;
   logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic ext_wr_req = 1'b0, ext_wr_allow;
   logic [AW-1:0] ext_wr_addr = '0;
   logic [DW-1:0] ext_data = '0;

   always #2.5 clk = ~clk;

   stbuf_fwd u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_cmp(req_cmp), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_ok(rsp_ok), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .line_locked(line_locked), .ext_wr_req(ext_wr_req),
      .ext_wr_addr(ext_wr_addr), .ext_wr_allow(ext_wr_allow)
   );

   // cache model
   logic [DW-1:0] mem [256];
   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
      end else begin
         if (mem_req && mem_we && mem_gnt)
            for (int l = 0; l < 4; l++)
               if (mem_be[l]) mem[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
         if (ext_wr_req && ext_wr_allow) mem[ext_wr_addr] <= ext_data;
      end
   end

   // grant modes: 0 random, 1 reads only, 2 always
   int gnt_mode = 2;
   logic gnt_rand = 1'b1;
   bit ext_rand = 0;
   assign mem_gnt = (gnt_mode == 0) ? gnt_rand :
                    (gnt_mode == 1) ? (mem_req && !mem_we) : 1'b1;

   int checks = 0, bad = 0, cycles = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // bench view of queued stores, oldest first
   logic [AW-1:0] sh_addr [8];
   logic [DW-1:0] sh_data [8];
   logic [3:0]    sh_be   [8];
   int sh_n = 0;

   function automatic logic [31:0] f_merge(input logic [31:0] base, input logic [AW-1:0] a);
      logic [31:0] w = base;
      for (int i = 0; i < sh_n; i++)
         if (sh_addr[i] == a)
            for (int l = 0; l < 4; l++)
               if (sh_be[i][l]) w[l*8 +: 8] = sh_data[i][l*8 +: 8];
      return w;
   endfunction

   bit busy = 0;
   int exp_kind = 0;
   logic [AW-1:0] cur_addr = '0;
   logic [DW-1:0] cur_new = '0, cur_cmp = '0, exp_word = '0;
   bit exp_ok = 0, prev_rsp = 0;
   logic [DW-1:0] last_data = '0;
   bit last_ok = 0;

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   always @(negedge clk) begin
      gnt_rand = ($urandom % 4) != 0;
      if (ext_rand) begin
         ext_wr_req  = ($urandom % 3) != 0;
         ext_wr_addr = AW'($urandom % 8);
         ext_data    = $urandom;
      end
      #1;
      cycles++;
      if (cycles > 150000) begin
         chk(0, "watchdog", 32'(cycles), 0);
         summary();
      end
      if (rst_n) begin
         if (mem_req && mem_gnt && mem_we && !line_locked) begin
            chk(sh_n > 0, "R1 write without queued store", 32'(sh_n), 1);
            if (sh_n > 0) begin
               chk(mem_addr == sh_addr[0] && mem_be == sh_be[0], "R2 drain order addr/be",
                   {mem_be, 20'h0, mem_addr}, {sh_be[0], 20'h0, sh_addr[0]});
               chk((mem_wdata & {{8{mem_be[3]}},{8{mem_be[2]}},{8{mem_be[1]}},{8{mem_be[0]}}}) ==
                   (sh_data[0] & {{8{sh_be[0][3]}},{8{sh_be[0][2]}},{8{sh_be[0][1]}},{8{sh_be[0][0]}}}),
                   "R1 drain data", mem_wdata, sh_data[0]);
               for (int i = 0; i < 7; i++) begin
                  sh_addr[i] = sh_addr[i+1]; sh_data[i] = sh_data[i+1]; sh_be[i] = sh_be[i+1];
               end
               sh_n--;
            end
         end
         if (mem_req && mem_gnt && mem_we && line_locked) begin
            chk(exp_ok, "R8 swap written on mismatch", 1, 32'(exp_ok));
            chk(mem_addr == cur_addr && mem_wdata == cur_new && mem_be == 4'hF,
                "R8 swap write", mem_wdata, cur_new);
         end
         if (mem_req && mem_gnt && !mem_we) begin
            if (line_locked) begin
               chk(sh_n == 0, "R6 queue empty before locked read", 32'(sh_n), 0);
               exp_kind = 2;
               exp_word = mem[mem_addr];
               exp_ok   = (mem[mem_addr] == cur_cmp);
            end else begin
               exp_kind = 1;
               exp_word = f_merge(mem[mem_addr], mem_addr);
            end
         end
         if (ext_wr_req)
            chk(ext_wr_allow == !(line_locked && ext_wr_addr[AW-1:2] == cur_addr[AW-1:2]),
                "R7 ext gate", 32'(ext_wr_allow), 32'(!(line_locked && ext_wr_addr[AW-1:2] == cur_addr[AW-1:2])));
         if (rsp_valid) begin
            chk(!prev_rsp, "R9 response pulse", 1, 0);
            chk(exp_kind != 0, "R9 unexpected response", 32'(exp_kind), 1);
            if (exp_kind == 1) chk(rsp_data == exp_word, "R4 load merge", rsp_data, exp_word);
            if (exp_kind == 2) begin
               chk(rsp_data == exp_word, "R8 swap old word", rsp_data, exp_word);
               chk(rsp_ok == exp_ok, "R8 swap ok", 32'(rsp_ok), 32'(exp_ok));
               chk(mem[cur_addr] == (exp_ok ? cur_new : exp_word), "R8 swap memory",
                   mem[cur_addr], exp_ok ? cur_new : exp_word);
               chk(!line_locked, "R7 lock released", 32'(line_locked), 0);
            end
            last_data = rsp_data;
            last_ok   = rsp_ok;
            exp_kind  = 0;
            busy      = 0;
         end
         prev_rsp = rsp_valid;
      end
   end

   task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic [31:0] cmp);
      @(negedge clk);
      req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_be = be; req_cmp = cmp;
      forever begin
         #1;
         if (req_ready) begin
            if (op == 2'b00) begin
               sh_addr[sh_n] = a; sh_data[sh_n] = d; sh_be[sh_n] = be; sh_n++;
            end else begin
               busy = 1; cur_addr = a; cur_new = d; cur_cmp = cmp;
            end
            @(negedge clk);
            req_valid = 0;
            break;
         end
         @(negedge clk);
      end
      while (busy) @(negedge clk);
   endtask

   task automatic ext_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      ext_wr_req = 1; ext_wr_addr = a; ext_data = d;
      @(negedge clk);
      ext_wr_req = 0;
   endtask

   task automatic wait_drain();
      while (sh_n != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1.2;
      chk(req_ready == 1, "R10 ready after reset", 32'(req_ready), 1);
      chk(mem_req == 0, "R10 no cache access after reset", 32'(mem_req), 0);
      chk(line_locked == 0, "R10 unlocked after reset", 32'(line_locked), 0);
      chk(rsp_valid == 0, "R10 no response after reset", 32'(rsp_valid), 0);

      // word that never existed
      gnt_mode = 1;
      ext_write(5, 32'h01010101);
      do_op(2'b00, 5, 32'h00000003, 4'b0001, 0);
      repeat (3) @(negedge clk);
      #1.2 chk(mem[5] == 32'h01010101, "R1 store not yet in cache", mem[5], 32'h01010101);
      do_op(2'b01, 5, 0, 0, 0);
      chk(last_data == 32'h01010103, "R4 stale upper lanes", last_data, 32'h01010103);
      ext_write(5, 32'h02020202);
      gnt_mode = 2;
      wait_drain();
      #1.2 chk(mem[5] == 32'h02020203, "R1 late drain result", mem[5], 32'h02020203);

      // youngest lane wins, full stall
      gnt_mode = 1;
      do_op(2'b00, 2, 32'hAAAAAAAA, 4'b1111, 0);
      do_op(2'b00, 2, 32'h0000BB00, 4'b0010, 0);
      do_op(2'b00, 2, 32'hCCDD0000, 4'b1100, 0);
      do_op(2'b00, 2, 32'hEE000000, 4'b1000, 0);
      @(negedge clk);
      req_valid = 1; req_op = 2'b00; req_addr = 3; req_wdata = 32'h77; req_be = 4'b0001;
      #1 chk(req_ready == 0, "R3 stall when full", 32'(req_ready), 0);
      #0.5 req_valid = 0;
      do_op(2'b01, 2, 0, 0, 0);
      chk(last_data == 32'hEEDDBBAA, "R5 youngest per lane", last_data, 32'hEEDDBBAA);
      gnt_mode = 2;
      wait_drain();
      #1.2 chk(mem[2] == 32'hEEDDBBAA, "R2 in-order drain result", mem[2], 32'hEEDDBBAA);

      // compare-and-swap after a queued store
      ext_write(1, 32'h11112222);
      gnt_mode = 1;
      do_op(2'b00, 1, 32'h55000000, 4'b1000, 0);
      gnt_mode = 2;
      do_op(2'b10, 1, 32'h33334444, 0, 32'h55112222);
      chk(last_ok == 1, "R8 swap succeeds", 32'(last_ok), 1);
      #1.2 chk(mem[1] == 32'h33334444, "R8 new value stored", mem[1], 32'h33334444);
      do_op(2'b10, 1, 32'h00000009, 0, 32'h0);
      chk(last_ok == 0, "R8 swap fails", 32'(last_ok), 0);
      #1.2 chk(mem[1] == 32'h33334444, "R8 unchanged on fail", mem[1], 32'h33334444);

      // random traffic
      gnt_mode = 0;
      ext_rand = 1;
      for (int n = 0; n < 400; n++) begin
         int k = $urandom % 20;
         logic [AW-1:0] a = AW'($urandom % 8);
         logic [3:0] be;
         int s = $urandom % 7;
         be = (s < 4) ? 4'(1 << s) : (s == 4) ? 4'b0011 : (s == 5) ? 4'b1100 : 4'b1111;
         if (k < 12)      do_op(2'b00, a, $urandom, be, 0);
         else if (k < 17) do_op(2'b01, a, 0, 0, 0);
         else             do_op(2'b10, a, $urandom, 0, ($urandom % 2) ? mem[a] : $urandom);
      end
      ext_rand = 0;
      ext_wr_req = 0;
      gnt_mode = 2;
      wait_drain();
      summary();
   end
endmodule